// File: doc/BRIEF.md
# Window Framebuffer Fetch Address Generator

This block walks one overlay window's framebuffer during a frame and emits the memory read bursts that bring it in, line by line. Configuration gives the first byte of the window in memory, the address at which the frame ends, the number of bytes to skip after each visible line, the window's pixel width and its bits per pixel. From the last two the block derives the visible line length in bytes. It also picks a burst size: short bursts for narrow windows and long bursts for wide ones.

A one-cycle frame strobe, taken only while the channel enable is high, reloads the walk at the start address. Requests leave on a valid/ready port. A request carries a byte address and a beat count in 8-byte bus words. While `req_ready` is low, the request holds. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Configuration must stay steady while a frame is being fetched. Clearing the channel enable aborts the walk and withdraws any pending request, so no hold guarantee applies then. A new frame strobe also replaces any pending request.

Top module: `wfetch_addrgen`

## Requirements
- R1: After reset, `req_valid` is low, and it stays low until a frame strobe arrives with the channel enabled.
- R2: A frame strobe sampled with `chan_en` high causes `req_valid` to be high in the next cycle, with `req_addr` equal to `cfg_start_addr`. The exception is a frame that fetches nothing (R7).
- R3: The line length in bytes, from `cfg_bpp` and `cfg_width` (w), is w/8 for 1, w/4 for 2, w/2 for 4, w for 8, 2w for 16, 3w for 24 and 4w for 32, with integer division. Any other `cfg_bpp` value gives 3w.
- R4: A bus word is 8 bytes. When `cfg_width` <= 64, bursts are 4 words (32 bytes). Otherwise they are 16 words (128 bytes). `req_beats` gives the burst length in words.
- R5: Within a line, each accepted full burst advances the address by the burst size in bytes. The last burst of a line covers only the remaining bytes, and its `req_beats` is the remaining byte count divided by 8, rounded up.
- R6: The first burst of the next line starts at the end of the previous line plus `cfg_skip` bytes.
- R7: When the next line's address is at or beyond `cfg_end_addr`, no further request is raised. A frame whose line length is zero, or whose start is not below its end, raises no request.
- R8: While `chan_en` is low, frame strobes are ignored. Clearing `chan_en` mid-frame makes `req_valid` low from the next cycle on.
- R9: While `req_valid` is high and `req_ready` is low, the request keeps `req_valid`, `req_addr` and `req_beats` unchanged in the next cycle. This does not apply if `chan_en` drops or a frame strobe arrives.
- R10: A frame strobe during a frame restarts the walk at `cfg_start_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_addr | input | AW | Byte address of the window's first fetched byte |
| cfg_end_addr | input | AW | Address at which fetching of the frame ends |
| cfg_skip | input | SKW | Bytes skipped after each visible line |
| cfg_bpp | input | 6 | Bits per pixel |
| cfg_width | input | PW | Window width in pixels |
| chan_en | input | 1 | Channel enable |
| frame_start | input | 1 | One-cycle frame strobe |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Burst request accepted this cycle when high with valid |
| req_addr | output | AW | Burst byte address |
| req_beats | output | BEAT_W | Burst length in 8-byte words |

## Verification
The bench builds the block with a 20-bit address, an 8-bit pixel width and a 12-bit skip field. This keeps every line at eight bursts or fewer, yet still lets widths cross the 64-pixel burst threshold. With these values it can sweep every bits-per-pixel code, including an unlisted one, against narrow, boundary and wide widths. It also exercises several skip values and three ready patterns, and compares each accepted request with a list computed arithmetically. The zero-length-line case, the empty frame, the mid-frame abort and the mid-frame restart are each driven directly.

// File: rtl/wfetch_pkg.sv
package wfetch_pkg;
  localparam int WORD_BYTES = 8;
  typedef enum logic {BURST_SHORT = 1'b0, BURST_LONG = 1'b1} burst_cls_e;
endpackage

// File: rtl/wfetch_linelen.sv
module wfetch_linelen #(
  parameter int PW  = 12,
  parameter int LBW = PW + 2
) (
  input  logic [5:0]     bpp,
  input  logic [PW-1:0]  width,
  output logic [LBW-1:0] line_bytes
);
  logic [LBW-1:0] wx;
  assign wx = LBW'(width);

  always_comb begin
    case (bpp)
      6'd1:    line_bytes = wx >> 3;
      6'd2:    line_bytes = wx >> 2;
      6'd4:    line_bytes = wx >> 1;
      6'd8:    line_bytes = wx;
      6'd16:   line_bytes = wx << 1;
      6'd32:   line_bytes = wx << 2;
      default: line_bytes = (wx << 1) + wx;  // 24 bpp and any unlisted code
    endcase
  end
endmodule

// File: rtl/wfetch_burst.sv
module wfetch_burst
  import wfetch_pkg::*;
#(
  parameter int LBW         = 14,
  parameter int SHORT_WORDS = 4,
  parameter int LONG_WORDS  = 16,
  parameter int BEAT_W      = $clog2(LONG_WORDS + 1)
) (
  input  logic [LBW-1:0]    remaining,
  input  burst_cls_e        cls,
  output logic [LBW-1:0]    chunk,
  output logic [BEAT_W-1:0] beats
);
  localparam logic [LBW-1:0] SHORT_BYTES = LBW'(SHORT_WORDS * WORD_BYTES);
  localparam logic [LBW-1:0] LONG_BYTES  = LBW'(LONG_WORDS * WORD_BYTES);
  localparam int             WSH         = $clog2(WORD_BYTES);

  logic [LBW-1:0] full;
  logic [LBW:0]   rounded;

  assign full    = (cls == BURST_LONG) ? LONG_BYTES : SHORT_BYTES;
  assign chunk   = (remaining > full) ? full : remaining;
  assign rounded = {1'b0, chunk} + (LBW + 1)'(WORD_BYTES - 1);
  assign beats   = BEAT_W'(rounded >> WSH);
endmodule

// File: rtl/wfetch_addrgen.sv
module wfetch_addrgen
  import wfetch_pkg::*;
#(
  parameter int AW          = 32,
  parameter int PW          = 12,
  parameter int SKW         = 16,
  parameter int NARROW_MAX  = 64,
  parameter int SHORT_WORDS = 4,
  parameter int LONG_WORDS  = 16,
  localparam int BEAT_W     = $clog2(LONG_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cfg_start_addr,
  input  logic [AW-1:0]     cfg_end_addr,
  input  logic [SKW-1:0]    cfg_skip,
  input  logic [5:0]        cfg_bpp,
  input  logic [PW-1:0]     cfg_width,
  input  logic              chan_en,
  input  logic              frame_start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic [BEAT_W-1:0] req_beats
);
  localparam int LBW = PW + 2;

  logic              active;
  logic [AW-1:0]     cur_addr;
  logic [LBW-1:0]    rem;
  logic [LBW-1:0]    lb_q;
  burst_cls_e        cls_q;
  logic [LBW-1:0]    lb_now;
  burst_cls_e        cls_now;
  logic [LBW-1:0]    chunk;
  logic [BEAT_W-1:0] beats;
  logic              line_done;
  logic [AW-1:0]     line_next;

  wfetch_linelen #(.PW(PW), .LBW(LBW)) u_len (
    .bpp(cfg_bpp), .width(cfg_width), .line_bytes(lb_now)
  );

  assign cls_now = (cfg_width <= PW'(NARROW_MAX)) ? BURST_SHORT : BURST_LONG;

  wfetch_burst #(
    .LBW(LBW), .SHORT_WORDS(SHORT_WORDS), .LONG_WORDS(LONG_WORDS), .BEAT_W(BEAT_W)
  ) u_burst (
    .remaining(rem), .cls(cls_q), .chunk(chunk), .beats(beats)
  );

  assign line_done = (rem <= chunk);
  assign line_next = cur_addr + AW'(rem) + AW'(cfg_skip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_addr <= '0;
      rem      <= '0;
      lb_q     <= '0;
      cls_q    <= BURST_SHORT;
    end else if (!chan_en) begin
      active <= 1'b0;
    end else if (frame_start) begin
      cur_addr <= cfg_start_addr;
      rem      <= lb_now;
      lb_q     <= lb_now;
      cls_q    <= cls_now;
      active   <= (lb_now != '0) && (cfg_start_addr < cfg_end_addr);
    end else if (active && req_ready) begin
      if (!line_done) begin
        cur_addr <= cur_addr + AW'(chunk);
        rem      <= rem - chunk;
      end else begin
        cur_addr <= line_next;
        rem      <= lb_q;
        if (line_next >= cfg_end_addr) active <= 1'b0;
      end
    end
  end

  assign req_valid = active;
  assign req_addr  = cur_addr;
  assign req_beats = beats;

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !req_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && chan_en && !frame_start)
      |=> (req_valid && $stable(req_addr) && $stable(req_beats)));

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && frame_start) |=> (req_addr == $past(cfg_start_addr)));

  assert_below_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr < cfg_end_addr));

  assert_beats_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0 && req_beats <= BEAT_W'(LONG_WORDS)));
endmodule

// File: tb/wfetch_addrgen_test.sv
module wfetch_addrgen_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int PW = 8;
  localparam int SKW = 12;
  localparam int BEAT_W = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] cfg_start_addr = '0, cfg_end_addr = '0;
  logic [SKW-1:0] cfg_skip = '0;
  logic [5:0] cfg_bpp = 6'd8;
  logic [PW-1:0] cfg_width = '0;
  logic chan_en = 0, frame_start = 0, req_ready = 0;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [BEAT_W-1:0] req_beats;

  int checks = 0, fails = 0;
  int exp_addr [0:255];
  int exp_beats[0:255];
  int n_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  wfetch_addrgen #(.AW(AW), .PW(PW), .SKW(SKW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cfg_skip(cfg_skip), .cfg_bpp(cfg_bpp), .cfg_width(cfg_width), .chan_en(chan_en),
    .frame_start(frame_start), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_lb(input int bp, input int w);
    if (bp == 1) return w / 8;
    if (bp == 2) return w / 4;
    if (bp == 4) return w / 2;
    if (bp == 8) return w;
    if (bp == 16) return w * 2;
    if (bp == 32) return w * 4;
    return w * 3;
  endfunction

  // builds the expected request list; returns frame end address
  function automatic int build(input int st, input int sk, input int bp, input int w, input int h);
    int lb, bb, en, a;
    lb = ref_lb(bp, w);
    bb = (w <= 64) ? 32 : 128;
    en = st + h * (lb + sk);
    n_exp = 0;
    a = st;
    if (lb > 0 && st < en) begin
      while (a < en) begin
        int r;
        r = lb;
        while (r > 0) begin
          int c;
          c = (r < bb) ? r : bb;
          exp_addr[n_exp] = a;
          exp_beats[n_exp] = (c + 7) / 8;
          n_exp++;
          a += c;
          r -= c;
        end
        a += sk;
      end
    end
    return en;
  endfunction

  function automatic bit rdy(input int cyc, input int pat);
    if (pat == 0) return 1'b1;
    if (pat == 1) return cyc[0];
    return (cyc % 3) != 0;
  endfunction

  task automatic strobe();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  // runs a frame; stop_after >= 0 stops after that many accepts
  task automatic run_frame(input int st, input int sk, input int bp, input int w, input int h,
                           input int pat, input int stop_after);
    int en, idx, cyc;
    bit stalled;
    int st_addr;
    en = build(st, sk, bp, w, h);
    cfg_start_addr = AW'(st); cfg_end_addr = AW'(en);
    cfg_skip = SKW'(sk); cfg_bpp = 6'(bp); cfg_width = PW'(w);
    req_ready = 0;
    @(negedge clk);
    strobe();
    idx = 0; cyc = 0; stalled = 0; st_addr = 0;
    if (n_exp == 0) begin
      repeat (3) begin
        check(!req_valid, "R7 empty frame raises no request", int'(req_valid), 0);
        @(negedge clk);
      end
      return;
    end
    if (stop_after < 0)
      check(req_valid && req_addr == AW'(st), "R2 first request at start", int'(req_addr), st);
    while (idx < n_exp && cyc < 4000 && (stop_after < 0 || idx < stop_after)) begin
      req_ready = rdy(cyc, pat);
      #1;
      if (stalled)
        check(req_valid && int'(req_addr) == st_addr, "R9 held under back-pressure",
              int'(req_addr), st_addr);
      stalled = 0;
      if (req_valid && req_ready) begin
        check(int'(req_addr) == exp_addr[idx], "R3 R5 R6 burst address",
              int'(req_addr), exp_addr[idx]);
        check(int'(req_beats) == exp_beats[idx], "R4 R5 burst beats",
              int'(req_beats), exp_beats[idx]);
        idx++;
      end else if (req_valid) begin
        stalled = 1;
        st_addr = int'(req_addr);
      end
      cyc++;
      @(negedge clk);
    end
    req_ready = 0;
    if (stop_after < 0) begin
      check(idx == n_exp, "R5 all bursts issued", idx, n_exp);
      check(!req_valid, "R7 stop at end address", int'(req_valid), 0);
    end
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    check(!req_valid, "R1 reset idle", int'(req_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(!req_valid, "R1 idle after reset", int'(req_valid), 0);
    chan_en = 1;
    k = 0;
    foreach (exp_addr[i]) exp_addr[i] = 0;
    for (int b = 0; b < 8; b++) begin
      int bpv [8] = '{1, 2, 4, 8, 16, 24, 32, 5};
      for (int wi = 0; wi < 5; wi++) begin
        int wv [5] = '{64, 65, 24, 200, 255};
        // start from base + x offset * bytes per pixel + y offset * pitch
        int base, pitch, sk;
        sk = (k % 4) * 24;
        pitch = ref_lb(bpv[b], wv[wi]) + sk;
        base = 4096 + 3 * ((bpv[b] >= 8) ? bpv[b] / 8 : 1) + 2 * pitch;
        run_frame(base, sk, bpv[b], wv[wi], 1 + (k % 3), k % 3, -1);
        k++;
      end
    end
    // zero-length line: 1 bpp, width 3
    run_frame(100, 8, 1, 3, 2, 0, -1);
    // empty frame: zero height
    run_frame(200, 8, 8, 40, 0, 0, -1);
    // restart mid-frame
    run_frame(512, 16, 32, 100, 2, 0, 3);
    strobe();
    check(req_valid && req_addr == AW'(512), "R10 restart at start", int'(req_addr), 512);
    run_frame(512, 16, 32, 100, 2, 1, -1);
    // abort by clearing the enable
    run_frame(768, 0, 16, 120, 3, 0, 2);
    check(req_valid, "R8 frame in progress before abort", int'(req_valid), 1);
    chan_en = 0;
    @(negedge clk);
    check(!req_valid, "R8 abort on enable clear", int'(req_valid), 0);
    strobe();
    repeat (2) begin
      check(!req_valid, "R8 strobe ignored while disabled", int'(req_valid), 0);
      @(negedge clk);
    end
    chan_en = 1;
    run_frame(768, 0, 16, 120, 3, 2, -1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule